// File: doc/BRIEF.md
# PHY Address Auto-Detection Sequencer

This block is a small control sequencer that sits above an MDIO management engine and finds the address at which an Ethernet PHY answers. On a start pulse it first tries a caller-supplied default address, if one is flagged as present. When that address is absent or does not answer with the expected capabilities, it walks the whole address space from the highest address downward and stops at the first PHY whose basic status register looks valid.

Every probe is one read of PHY register 1 through the engine's request/idle handshake. The sequencer waits for the engine to be idle before it requests, then waits again for completion, and gives up on an address when either wait exceeds a configurable poll limit. The outcome is a found flag with the address, or a fail flag. Both stay unchanged until the next accepted start.

Top module: `phy_addr_finder`

## Requirements
- R1: After reset `busy_o`, `found_o`, `fail_o` and `rd_req_o` are low and `addr_o` is 0.
- R2: A start pulse while not busy clears `found_o`/`fail_o` and raises `busy_o` on the next cycle; a start pulse while busy, including one that lands in the cycle a read result is judged, has no effect on the search or its result.
- R3: Every read request is a one-cycle pulse on `rd_req_o` with `rd_reg_o` = 1, issued only while `mdio_idle_i` is high; the read data is taken from `rd_data_i` in the first cycle `mdio_idle_i` is high again. The engine contract is that it drops `mdio_idle_i` on the cycle after a request and holds `rd_data_i` while idle.
- R4: An address is valid only when the read word is not 0xFFFF and bits 12, 11 and 3 (mask 0x1808) are all set.
- R5: When the default-present flag is set at start and the default address is valid, the search ends found with that address after exactly one read.
- R6: Otherwise the addresses are read in the order 31, 30, ... 0 (the default address is read again in its turn) and the first valid one is reported as found.
- R7: When no address is valid the search ends with `fail_o` high and `addr_o` = 0.
- R8: If the engine stays busy for TIMEOUT_POLLS consecutive polls, either before the request (no read is issued) or after it, that address counts as invalid and the search moves on.
- R9: `found_o`, `fail_o` and `addr_o` hold their values until the next accepted start; `found_o` and `fail_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a new search |
| dflt_valid_i | input | 1 | Default address present, sampled at start |
| dflt_addr_i | input | AW | Default address, sampled at start |
| mdio_idle_i | input | 1 | Management engine idle |
| rd_data_i | input | DW | Read data from the engine |
| rd_req_o | output | 1 | Read request pulse to the engine |
| rd_phy_o | output | AW | PHY address of the read |
| rd_reg_o | output | 5 | Register number of the read (always 1) |
| busy_o | output | 1 | Search in progress |
| found_o | output | 1 | Search ended with a valid address |
| fail_o | output | 1 | Search ended with no valid address |
| addr_o | output | AW | Found address, 0 otherwise |

## Verification
The two events that can share a cycle are a new start pulse and the judgement of a returned read, which also decides whether the search advances or ends. The bench watches the engine model's idle line rise and drives a start with a different, valid default address into exactly the cycle the sequencer samples that read. It then judges by the scoreboard: the sequence of read addresses and the final result must match those computed for the original, uninterrupted search.

// File: rtl/phyf_pkg.sv
package phyf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_REQ  = 3'd2,
    ST_GAP  = 3'd3,
    ST_POST = 3'd4
  } phyf_state_e;

  localparam logic [4:0] STATUS_REG_NUM = 5'd1;
endpackage

// File: rtl/phyf_poll_timer.sv
module phyf_poll_timer #(
  parameter int LIMIT = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/phyf_judge.sv
module phyf_judge #(
  parameter int DW = 16,
  parameter logic [15:0] CAP_MASK = 16'h1808
) (
  input  logic [DW-1:0] word_i,
  output logic          ok_o
);
  localparam logic [DW-1:0] MASK = DW'(CAP_MASK);

  always_comb begin
    ok_o = (word_i != {DW{1'b1}}) && ((word_i & MASK) == MASK);
  end
endmodule

// File: rtl/phyf_addr_cursor.sv
module phyf_addr_cursor #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          dec_i,
  output logic [AW-1:0] cur_o,
  output logic          at_zero_o
);
  logic [AW-1:0] cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (load_i) begin
      cur_q <= load_val_i;
    end else if (dec_i) begin
      cur_q <= cur_q - 1'b1;
    end
  end

  assign cur_o     = cur_q;
  assign at_zero_o = (cur_q == '0);
endmodule

// File: rtl/phy_addr_finder.sv
module phy_addr_finder
  import phyf_pkg::*;
#(
  parameter int          AW            = 5,
  parameter int          DW            = 16,
  parameter int          TIMEOUT_POLLS = 20000,
  parameter logic [15:0] CAP_MASK      = 16'h1808
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          dflt_valid_i,
  input  logic [AW-1:0] dflt_addr_i,
  input  logic          mdio_idle_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_phy_o,
  output logic [4:0]    rd_reg_o,
  output logic          busy_o,
  output logic          found_o,
  output logic          fail_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

  phyf_state_e   state_q, state_d;
  logic          in_dflt_q, in_dflt_d;
  logic          found_q, found_d;
  logic          fail_q, fail_d;
  logic [AW-1:0] addr_q, addr_d;

  logic          start_ok;
  logic          verdict, verdict_ok, go_scan, go_dec;
  logic          cur_load;
  logic [AW-1:0] cur_load_val;
  logic [AW-1:0] cur;
  logic          cur_zero;
  logic          tmr_clr, tmr_en, tmr_exp;
  logic          word_ok;

  phyf_poll_timer #(.LIMIT(TIMEOUT_POLLS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (tmr_clr),
    .en_i      (tmr_en),
    .expired_o (tmr_exp)
  );

  phyf_judge #(.DW(DW), .CAP_MASK(CAP_MASK)) u_judge (
    .word_i (rd_data_i),
    .ok_o   (word_ok)
  );

  phyf_addr_cursor #(.AW(AW)) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cur_load),
    .load_val_i (cur_load_val),
    .dec_i      (go_dec),
    .cur_o      (cur),
    .at_zero_o  (cur_zero)
  );

  assign start_ok = start_i && (state_q == ST_IDLE);
  assign tmr_en   = ((state_q == ST_PRE) || (state_q == ST_POST)) && !mdio_idle_i;

  // next-state process
  always_comb begin
    state_d    = state_q;
    in_dflt_d  = in_dflt_q;
    found_d    = found_q;
    fail_d     = fail_q;
    addr_d     = addr_q;
    verdict    = 1'b0;
    verdict_ok = 1'b0;
    go_scan    = 1'b0;
    go_dec     = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_PRE;
          in_dflt_d = dflt_valid_i;
          found_d   = 1'b0;
          fail_d    = 1'b0;
          addr_d    = '0;
        end
      end
      ST_PRE: begin
        if (mdio_idle_i) begin
          state_d = ST_REQ;
        end else if (tmr_exp) begin
          verdict = 1'b1;
        end
      end
      ST_REQ:  state_d = ST_GAP;
      ST_GAP:  state_d = ST_POST;
      ST_POST: begin
        if (mdio_idle_i) begin
          verdict    = 1'b1;
          verdict_ok = word_ok;
        end else if (tmr_exp) begin
          verdict = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (verdict) begin
      if (verdict_ok) begin
        state_d = ST_IDLE;
        found_d = 1'b1;
        addr_d  = cur;
      end else if (in_dflt_q) begin
        state_d   = ST_PRE;
        in_dflt_d = 1'b0;
        go_scan   = 1'b1;
      end else if (cur_zero) begin
        state_d = ST_IDLE;
        fail_d  = 1'b1;
      end else begin
        state_d = ST_PRE;
        go_dec  = 1'b1;
      end
    end
  end

  assign cur_load     = start_ok || go_scan;
  assign cur_load_val = (start_ok && dflt_valid_i) ? dflt_addr_i : TOP_ADDR;
  assign tmr_clr      = (state_d != state_q) || verdict;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      in_dflt_q <= 1'b0;
      found_q   <= 1'b0;
      fail_q    <= 1'b0;
      addr_q    <= '0;
    end else begin
      state_q   <= state_d;
      in_dflt_q <= in_dflt_d;
      found_q   <= found_d;
      fail_q    <= fail_d;
      addr_q    <= addr_d;
    end
  end

  assign rd_req_o = (state_q == ST_REQ);
  assign rd_phy_o = cur;
  assign rd_reg_o = STATUS_REG_NUM;
  assign busy_o   = (state_q != ST_IDLE);
  assign found_o  = found_q;
  assign fail_o   = fail_q;
  assign addr_o   = addr_q;
endmodule

// File: rtl/phyf_checker.sv
module phyf_checker #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          mdio_idle_i,
  input logic          rd_req_o,
  input logic          busy_o,
  input logic          found_o,
  input logic          fail_o,
  input logic [AW-1:0] addr_o
);
  assert_req_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> mdio_idle_i);

  assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  assert_cleared_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!found_o && !fail_o));

  assert_fail_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (addr_o == '0));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(found_o && fail_o));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(found_o) && $stable(fail_o) && $stable(addr_o)));
endmodule

bind phy_addr_finder phyf_checker #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .mdio_idle_i (mdio_idle_i),
  .rd_req_o    (rd_req_o),
  .busy_o      (busy_o),
  .found_o     (found_o),
  .fail_o      (fail_o),
  .addr_o      (addr_o)
);

// File: tb/tb_phy_addr_finder.sv
module tb_phy_addr_finder;
  localparam int AW    = 5;
  localparam int DW    = 16;
  localparam int LIMIT = 16;
  localparam int LAT   = 3;
  localparam int HANG  = 24;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic          dflt_valid_i;
  logic [AW-1:0] dflt_addr_i;
  logic          mdio_idle_i;
  logic [DW-1:0] rd_data_i;
  logic          rd_req_o;
  logic [AW-1:0] rd_phy_o;
  logic [4:0]    rd_reg_o;
  logic          busy_o;
  logic          found_o;
  logic          fail_o;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int fails  = 0;

  phy_addr_finder #(.AW(AW), .DW(DW), .TIMEOUT_POLLS(LIMIT)) dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // engine model
  logic [DW-1:0] resp [32];
  logic          eng_idle;
  int            eng_left;
  logic [AW-1:0] eng_addr;
  bit            stall   = 0;
  bit            hang_en = 0;
  int            hang_a  = 0;

  assign mdio_idle_i = eng_idle && !stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_idle  <= 1'b1;
      eng_left  <= 0;
      eng_addr  <= '0;
      rd_data_i <= '0;
    end else if (rd_req_o && mdio_idle_i) begin
      eng_idle <= 1'b0;
      eng_addr <= rd_phy_o;
      eng_left <= (hang_en && (int'(rd_phy_o) == hang_a)) ? HANG : LAT;
    end else if (!eng_idle) begin
      if (eng_left == 1) begin
        eng_idle  <= 1'b1;
        rd_data_i <= resp[eng_addr];
      end
      eng_left <= eng_left - 1;
    end
  end

  // scoreboard
  int            exp_rd_q [$];
  logic [6:0]    exp_res_q [$];
  bit            busy_d = 0;

  task automatic check(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_req_o) begin
        if (exp_rd_q.size() == 0) begin
          check("R6 unexpected read", 1'b0, int'(rd_phy_o), -1);
        end else begin
          int e;
          e = exp_rd_q.pop_front();
          check("R6 read address order", int'(rd_phy_o) == e, int'(rd_phy_o), e);
          check("R3 read register", rd_reg_o == 5'd1, int'(rd_reg_o), 1);
        end
      end
      if (busy_d && !busy_o) begin
        if (exp_res_q.size() == 0) begin
          check("R9 unexpected result", 1'b0, 0, 0);
        end else begin
          logic [6:0] e;
          e = exp_res_q.pop_front();
          check("R5/R6/R7 result", {found_o, fail_o, addr_o} == e,
                int'({found_o, fail_o, addr_o}), int'(e));
        end
      end
    end
    busy_d = busy_o;
  end

  function automatic bit addr_ok(int a);
    if (stall) return 1'b0;
    if (hang_en && a == hang_a) return 1'b0;
    return (resp[a] != 16'hFFFF) && ((resp[a] & 16'h1808) == 16'h1808);
  endfunction

  task automatic fill_resp(logic [DW-1:0] v);
    for (int i = 0; i < 32; i++) resp[i] = v;
  endtask

  task automatic expect_search(bit dv, int da);
    bit fnd = 0;
    int fa  = 0;
    if (dv) begin
      if (!stall) exp_rd_q.push_back(da);
      if (addr_ok(da)) begin fnd = 1; fa = da; end
    end
    if (!fnd) begin
      for (int a = 31; a >= 0; a--) begin
        if (!stall) exp_rd_q.push_back(a);
        if (addr_ok(a)) begin fnd = 1; fa = a; break; end
      end
    end
    exp_res_q.push_back({fnd, !fnd, AW'(fnd ? fa : 0)});
  endtask

  // intrude: number of starts to inject in judgement cycles while busy
  task automatic run(bit dv, int da, int intrude);
    bit idle_prev;
    int done_intr = 0;
    expect_search(dv, da);
    @(negedge clk);
    dflt_valid_i = dv;
    dflt_addr_i  = AW'(da);
    start_i      = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after start", busy_o && !found_o && !fail_o,
          int'({busy_o, found_o, fail_o}), 3'b100);
    idle_prev = mdio_idle_i;
    while (busy_o) begin
      @(negedge clk);
      start_i = 1'b0;
      if (busy_o && mdio_idle_i && !idle_prev && done_intr < intrude) begin
        // start lands in the cycle the returned word is judged
        start_i      = 1'b1;
        dflt_valid_i = 1'b1;
        dflt_addr_i  = 5'd4;
        done_intr++;
      end
      idle_prev = mdio_idle_i;
    end
    start_i = 1'b0;
    @(negedge clk);
    check("R3 read count", exp_rd_q.size() == 0, exp_rd_q.size(), 0);
    exp_rd_q.delete();
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [6:0] held;
    rst_n        = 1'b0;
    start_i      = 1'b0;
    dflt_valid_i = 1'b0;
    dflt_addr_i  = '0;
    fill_resp(16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", {busy_o, found_o, fail_o, rd_req_o, addr_o} == '0,
          int'({busy_o, found_o, fail_o, rd_req_o, addr_o}), 0);

    // R5: valid default, single read
    fill_resp(16'h0000); resp[5] = 16'h7809;
    run(1, 5, 0);

    // R6: no default, first valid from the top wins
    fill_resp(16'h0000); resp[20] = 16'h1808; resp[7] = 16'h1808;
    run(0, 0, 0);

    // R6: failing default, then full scan
    fill_resp(16'h0000); resp[9] = 16'hFFFF; resp[3] = 16'h180C;
    run(1, 9, 0);

    // R4: all-ones and partial masks rejected
    fill_resp(16'h0000);
    resp[31] = 16'hFFFF; resp[30] = 16'h1800; resp[29] = 16'h1008;
    resp[28] = 16'h0808; resp[27] = 16'h1808;
    run(0, 0, 0);

    // R7: nothing answers
    fill_resp(16'h07F7);
    run(1, 12, 0);

    // R6 boundary: only address 0 valid
    fill_resp(16'h0000); resp[0] = 16'hF80F;
    run(0, 0, 0);

    // R8: completion timeout at 25 treated as invalid
    fill_resp(16'h0000); resp[25] = 16'h1808; resp[12] = 16'h1808;
    hang_en = 1; hang_a = 25;
    run(0, 0, 0);
    hang_en = 0;
    repeat (HANG) @(negedge clk);

    // R8: engine never idle, every pre-wait times out, no read issued
    fill_resp(16'h1808);
    stall = 1;
    run(1, 6, 0);
    stall = 0;

    // R2: starts during judgement cycles are ignored
    fill_resp(16'h0000); resp[10] = 16'h1808; resp[4] = 16'h1808;
    run(0, 0, 3);

    // R9: result held while idle
    held = {found_o, fail_o, addr_o};
    repeat (40) @(negedge clk);
    check("R9 result held", {found_o, fail_o, addr_o} == held,
          int'({found_o, fail_o, addr_o}), int'(held));
    check("R9 found and fail exclusive", !(found_o && fail_o),
          int'({found_o, fail_o}), 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule